// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block sits between a synchronous requester and an asynchronous static RAM of 32K words by 8 bits. A requester hands over one write at a time through a valid/ready handshake: the 15-bit word address and the 8-bit data are captured on the clock edge where `req_valid` and `req_ready` are both high. The block then plays out a complete write cycle on the memory pins. These pins are a write strobe and a select that are both active low, an enable that is active high, the address, and the data with its own driver-enable.

Every phase length is a whole number of clocks. Each one is derived when the design is elaborated, by ceiling division of a nanosecond limit by `CLK_PERIOD_NS`. The write strobe is held low for the longest of these three spans:
- the strobe width;
- the address-to-end window and the select-to-end window;
- the memory's output-release window plus the data setup window.

This lets the block turn its own data drivers on only after the memory has released the bus, and still meet data setup. A recovery phase with the strobe high follows before the next cycle can start.

Back-pressure works as follows. `req_ready` is low for the whole cycle and the recovery after it. A request presented while ready is low is not taken and has no effect. The requester must hold `req_valid` and its payload until it sees ready. `done` marks the end of each cycle for one clock, and a new request may be accepted in that same clock.

Top module: `sram_wr_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `mem_we_n` and `mem_cs_n` are 1, `mem_ce` is 0, `mem_dq_oe` is 0, `busy` and `done` are 0, and `req_ready` is 1.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. From the next clock, `mem_addr` and `mem_dq` show the captured address and data.
- R3: `mem_we_n` goes low in the first clock after acceptance. It stays low for exactly PULSE clocks, where PULSE = max(ceil(20/T), ceil(13/T)+ceil(15/T)) and T is `CLK_PERIOD_NS`. With the default T = 4, PULSE is 8.
- R4: `mem_cs_n` is 0 and `mem_ce` is 1 in exactly the clocks where `mem_we_n` is 0. Otherwise `mem_cs_n` is 1 and `mem_ce` is 0.
- R5: `mem_dq_oe` is 0 in the first ceil(13/T) clocks of the strobe pulse and 1 in the remaining clocks of the pulse. It is 0 from the clock in which `mem_we_n` returns high. At the default, the drivers are on in pulse clocks 5 to 8.
- R6: After the pulse, `mem_we_n` stays high for ceil(5/T) recovery clocks (2 at the default) before ready returns. One write therefore occupies PULSE plus recovery clocks (10 at the default).
- R7: `req_ready` is 0 and `busy` is 1 from the clock after acceptance until recovery ends. `req_valid` presented in that span is ignored: the address, data and strobe timing of the current cycle are unchanged, and no extra cycle follows.
- R8: `done` is 1 for exactly one clock, the first clock after recovery. In that clock `req_ready` is 1 and `busy` is 0, and a request offered in that clock starts the next cycle at once.
- R9: `mem_addr` and `mem_dq` stay stable from acceptance through the whole pulse and for at least one clock after `mem_we_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_PERIOD_NS` |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 15 | Word address of the request |
| req_data | input | 8 | Data byte of the request |
| busy | output | 1 | A write or its recovery is in progress |
| done | output | 1 | One-clock pulse when a write finishes |
| mem_addr | output | 15 | Address to the memory |
| mem_dq | output | 8 | Data value toward the memory |
| mem_dq_oe | output | 1 | Enables the data drivers toward the memory |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip enable, active high |

## Verification
Isolated writes with idle gaps show that the strobe, the select and the driver window start and stop at the computed clock offsets. Chained writes, each offered in the `done` clock, separate a correct recovery length from one that is too short or too long. Random valid pulses with changing payloads during a busy cycle show whether anything leaks into the captured address and data or starts a cycle. Random addresses and data, including all-zero and all-one patterns, expose bit swaps and latching errors.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RECOV = 2'd2
  } wr_state_e;

  // clocks needed to cover t_ns, never less than one
  function automatic int clk_span(input int t_ns, input int period_ns);
    int c;
    c = (t_ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_capture.sv
module sram_wr_capture #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_o <= '0;
      data_o <= '0;
    end else if (load) begin
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end

  // payload only moves on an accepted request
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(addr_o) && $stable(data_o)));

endmodule

// File: rtl/sram_wr_sequencer.sv
module sram_wr_sequencer
  import sram_wr_pkg::*;
#(
  parameter int PULSE_CYC = 8,
  parameter int OPEN_CYC  = 4,
  parameter int REC_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic we_n,
  output logic cs_n,
  output logic ce,
  output logic dq_oe,
  output logic done
);

  localparam int CNT_W = $clog2(imax(PULSE_CYC, REC_CYC) + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] OPEN_AT    = CNT_W'(OPEN_CYC);

  wr_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fin_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    fin_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_PULSE;
          cnt_d   = '0;
        end
      end
      ST_PULSE: begin
        if (cnt_q == PULSE_LAST) begin
          state_d = ST_RECOV;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt_q == REC_LAST) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
          fin_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // strobes come straight from flops so the memory never sees a glitch
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      we_n    <= 1'b1;
      cs_n    <= 1'b1;
      ce      <= 1'b0;
      dq_oe   <= 1'b0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      we_n    <= (state_d != ST_PULSE);
      cs_n    <= (state_d != ST_PULSE);
      ce      <= (state_d == ST_PULSE);
      dq_oe   <= (state_d == ST_PULSE) && (cnt_d >= OPEN_AT);
      done    <= fin_d;
    end
  end

  assign busy = (state_q != ST_IDLE);

  assert_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!cs_n && ce));
  assert_drive_in_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);
  assert_data_before_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> $past(dq_oe));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && we_n));
  assert_pulse_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !we_n);

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_STROBE_NS   = 20,
  parameter int T_RECOVER_NS  = 5,
  parameter int T_DSETUP_NS   = 15,
  parameter int T_ASETUP_NS   = 20,
  parameter int T_SELECT_NS   = 20,
  parameter int T_RELEASE_NS  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq,
  output logic              mem_dq_oe,
  output logic              mem_we_n,
  output logic              mem_cs_n,
  output logic              mem_ce
);

  localparam int OPEN_CYC  = clk_span(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int DS_CYC    = clk_span(T_DSETUP_NS, CLK_PERIOD_NS);
  localparam int WIN_CYC   = imax(clk_span(T_ASETUP_NS, CLK_PERIOD_NS),
                                  clk_span(T_SELECT_NS, CLK_PERIOD_NS));
  localparam int PULSE_CYC = imax(imax(clk_span(T_STROBE_NS, CLK_PERIOD_NS), WIN_CYC),
                                  OPEN_CYC + DS_CYC);
  localparam int REC_CYC   = clk_span(T_RECOVER_NS, CLK_PERIOD_NS);

  logic seq_busy;
  logic accept;

  assign req_ready = !seq_busy;
  assign busy      = seq_busy;
  assign accept    = req_valid && req_ready;

  sram_wr_capture #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .addr_i(req_addr),
    .data_i(req_data),
    .addr_o(mem_addr),
    .data_o(mem_dq)
  );

  sram_wr_sequencer #(
    .PULSE_CYC(PULSE_CYC),
    .OPEN_CYC (OPEN_CYC),
    .REC_CYC  (REC_CYC)
  ) u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .busy (seq_busy),
    .we_n (mem_we_n),
    .cs_n (mem_cs_n),
    .ce   (mem_ce),
    .dq_oe(mem_dq_oe),
    .done (done)
  );

  // while the strobe is low the payload on the pins must not move
  assert_stable_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq)));
  assert_no_take_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(mem_addr));

endmodule

// File: tb/tb_sram_wr_ctrl.sv
module tb_sram_wr_ctrl;

  localparam int T = 4;

  function automatic int span(input int t);
    int c;
    c = (t + T - 1) / T;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int OPEN  = span(13);
  localparam int PULSE = (span(20) > OPEN + span(15)) ? span(20) : OPEN + span(15);
  localparam int REC   = span(5);

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_data = '0;
  logic        busy, done;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq;
  logic        mem_dq_oe, mem_we_n, mem_cs_n, mem_ce;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sram_wr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe),
    .mem_we_n(mem_we_n), .mem_cs_n(mem_cs_n), .mem_ce(mem_ce)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // expected pin values k clocks after acceptance
  function automatic logic exp_we_n(input int k);
    return !(k >= 1 && k <= PULSE);
  endfunction
  function automatic logic exp_oe(input int k);
    return (k > OPEN && k <= PULSE);
  endfunction

  // called at a negedge with req_ready high; returns at the done negedge
  task automatic do_write(input logic [14:0] a, input logic [7:0] d, input bit junk);
    req_valid = 1; req_addr = a; req_data = d;
    @(posedge clk);
    for (int k = 1; k <= PULSE + REC; k++) begin
      @(negedge clk);
      chk("R3 we_n", mem_we_n, exp_we_n(k));
      chk("R4 cs_n", mem_cs_n, exp_we_n(k));
      chk("R4 ce", mem_ce, !exp_we_n(k));
      chk("R5 dq_oe", mem_dq_oe, exp_oe(k));
      chk("R7 ready", req_ready, 1'b0);
      chk("R7 busy", busy, 1'b1);
      chk("R8 done low", done, 1'b0);
      if (k <= PULSE + 1) begin
        chk("R2 R9 addr", mem_addr, a);
        chk("R2 R9 data", mem_dq, d);
      end
      if (k > PULSE) chk("R7 addr kept", mem_addr, a);
      if (junk) begin
        req_valid = 1'($urandom_range(0, 1));
        req_addr  = 15'($urandom);
        req_data  = 8'($urandom);
      end else begin
        req_valid = 0;
      end
    end
    @(negedge clk);
    req_valid = 0;
    chk("R8 done", done, 1'b1);
    chk("R8 ready", req_ready, 1'b1);
    chk("R8 busy", busy, 1'b0);
    chk("R6 we_n high", mem_we_n, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 we_n", mem_we_n, 1'b1);
    chk("R1 cs_n", mem_cs_n, 1'b1);
    chk("R1 ce", mem_ce, 1'b0);
    chk("R1 oe", mem_dq_oe, 1'b0);
    chk("R1 ready", req_ready, 1'b1);
    chk("R1 busy", busy, 1'b0);
    chk("R1 done", done, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", mem_we_n, 1'b1);

    do_write(15'h0000, 8'h00, 0);
    do_write(15'h7FFF, 8'hFF, 0);   // back-to-back, R8
    @(negedge clk);
    chk("R8 done one clock", done, 1'b0);
    chk("R7 no extra cycle", mem_we_n, 1'b1);
    do_write(15'h5555, 8'hA5, 1);   // junk while busy, R7
    @(negedge clk);
    chk("R7 junk not taken", busy, 1'b0);

    for (int i = 0; i < 40; i++) begin
      do_write(15'($urandom), 8'($urandom), ($urandom_range(0, 1) == 1));
      if ($urandom_range(0, 2) == 0) begin
        repeat ($urandom_range(1, 3)) begin
          @(negedge clk);
          chk("R8 done idle", done, 1'b0);
          chk("R6 idle we_n", mem_we_n, 1'b1);
        end
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule